// File: doc/BRIEF.md
# Bit-Serial Multiply-Accumulate Unit

This block computes `A * B + C` on unsigned operands, one result bit per clock, least significant bit first. The multiplier `B` is presented in parallel with a start strobe. The multiplicand `A` and the addend `C` arrive as serial bit streams that begin in the strobe cycle. Inside, a cascade of one-bit serial adders forms the product. There is one adder per multiplier bit. Stage `j` is gated by bit `j` of `B` and adds a copy of the multiplicand stream delayed by `j` clocks, so it shifts it up `j` places, or adds zeros when its bit is clear. A further serial adder folds in the addend stream as each product bit emerges.

Each stage holds only a one-bit carry. Every result bit is final as soon as it is produced, so downstream logic can consume the low bits while the upper bits are still being formed. The result is `2N+1` bits wide, so the carry out of the accumulate step is kept. A valid flag marks the output bits, and a one-cycle done pulse follows the last bit.

Top module: `bitser_mac`

## Requirements
- R1: After a start, the `2N+1` bits emitted while `res_valid` is high, read LSB first, equal `A*B + C`. `A` is `N` bits, `B` is `N` bits and `C` is `2N` bits, all unsigned.
- R2: Result bit `k` (k = 0..2N) is on `res_bit` in the `(k+1)`-th cycle after the start cycle. `res_valid` is high in exactly those `2N+1` consecutive cycles.
- R3: `mcand_bit` is sampled as bit `i` of `A` in cycle `i` after start (i = 0..N-1, the start cycle being cycle 0). It is ignored from cycle `N` onward.
- R4: `addend_bit` is sampled as bit `i` of `C` in cycle `i` after start (i = 0..2N-1). It is ignored from cycle `2N` onward.
- R5: `mplr` is captured in the start cycle. Later changes on it do not affect the running result.
- R6: `done` is high for exactly one cycle, the cycle right after the last valid result bit.
- R7: `res_bit` is 0 whenever `res_valid` is low, and serial inputs driven while idle do not disturb it.
- R8: A start while a computation is running abandons it. The new result follows R1 and R2 timed from the new start.
- R9: A start is accepted in the cycle in which `done` is high. The two results follow one another with no gap.
- R10: While reset is held and after its release, `res_bit`, `res_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a computation; this cycle carries bit 0 of both streams |
| mplr | input | N | Multiplier `B`, sampled with `start` |
| mcand_bit | input | 1 | Serial multiplicand `A`, LSB first |
| addend_bit | input | 1 | Serial addend `C`, LSB first |
| res_bit | output | 1 | Serial result, LSB first |
| res_valid | output | 1 | High while `res_bit` carries a result bit |
| done | output | 1 | One-cycle pulse after the last result bit |

## Verification
On every cycle the assertions check the output framing:
- `res_valid` rises only the cycle after a start, and always does so.
- A valid run never exceeds `2N+1` bits and is exactly that long when `done` fires.
- `done` is a single-cycle pulse that closes the run.
- `res_bit` stays low outside a run.

Only the bench's scenarios can show that the bit values are arithmetically right. The bench reassembles the stream against `A*B+C` over every 4-bit operand pair. It also shows that late stream bits and late multiplier changes are ignored, and that restarts and back-to-back starts produce the right numbers.

// File: rtl/bsmac_pkg.sv
package bsmac_pkg;

  typedef struct packed {
    logic sum;
    logic carry;
  } fa_out_t;

  function automatic fa_out_t full_add(input logic x, input logic y, input logic z);
    fa_out_t r;
    r.sum   = x ^ y ^ z;
    r.carry = (x & y) | (x & z) | (y & z);
    return r;
  endfunction

endpackage

// File: rtl/bsmac_sadd.sv
// One-bit serial adder: the sum is combinational, the carry is held in a single flop.
module bsmac_sadd
  import bsmac_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  input  logic x,
  input  logic y,
  output logic sum
);

  logic    cy_q, cy_d, cin;
  fa_out_t fa;

  always_comb begin
    cin  = clr ? 1'b0 : cy_q;
    fa   = full_add(x, y, cin);
    sum  = fa.sum;
    cy_d = cy_q;
    if (en) cy_d = fa.carry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cy_q <= 1'b0;
    else        cy_q <= cy_d;
  end

endmodule

// File: rtl/bsmac_delay.sv
// Bit-wide delay line: taps[j] is the input stream delayed by j clocks.
module bsmac_delay #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic         din,
  output logic [N-1:0] taps
);

  assign taps[0] = din;

  if (N > 1) begin : g_line
    logic [N-2:0] d_q, d_d;

    always_comb begin
      d_d = d_q;
      if (en) d_d = taps[N-2:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) d_q <= '0;
      else        d_q <= d_d;
    end

    for (genvar j = 1; j < N; j++) begin : g_tap
      assign taps[j] = ~clr & d_q[j-1];
    end
  end

endmodule

// File: rtl/bsmac_seq.sv
// Sequencer: tracks the bit index of the running computation and opens the input windows.
module bsmac_seq #(
  parameter int N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active,
  output logic mcand_open,
  output logic addend_open,
  output logic last
);

  localparam int             CW   = $clog2(2 * N + 2);
  localparam logic [CW-1:0]  MEND = CW'(N);
  localparam logic [CW-1:0]  AEND = CW'(2 * N);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d, idx;

  always_comb begin
    active      = start | busy_q;
    idx         = start ? '0 : cnt_q;
    mcand_open  = active && (idx < MEND);
    addend_open = active && (idx < AEND);
    last        = active && (idx == AEND);
    busy_d      = busy_q;
    cnt_d       = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = CW'(1);
    end else if (busy_q) begin
      busy_d = (cnt_q != AEND);
      cnt_d  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

endmodule

// File: rtl/bitser_mac.sv
module bitser_mac #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] mplr,
  input  logic         mcand_bit,
  input  logic         addend_bit,
  output logic         res_bit,
  output logic         res_valid,
  output logic         done
);

  logic         active, mcand_open, addend_open, last;
  logic [N-1:0] gate_q, gate_d, gate_eff;
  logic [N-1:0] taps;
  logic         a_in, c_in, acc_sum;
  logic         res_d, valid_d, last_q, last_d, done_d;

  bsmac_seq #(.N(N)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .active(active), .mcand_open(mcand_open),
    .addend_open(addend_open), .last(last)
  );

  // Multiplier bits: live in the start cycle, held afterwards.
  always_comb begin
    gate_d = gate_q;
    if (start) gate_d = mplr;
    gate_eff = start ? mplr : gate_q;
    a_in     = mcand_open & mcand_bit;
    c_in     = addend_open & addend_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= '0;
    else        gate_q <= gate_d;
  end

  bsmac_delay #(.N(N)) u_dly (
    .clk(clk), .rst_n(rst_n), .en(active), .clr(start),
    .din(a_in), .taps(taps)
  );

  // Partial product cascade, least significant multiplier bit first.
  for (genvar j = 0; j < N; j++) begin : g_stage
    logic s_in, s_out;
    if (j == 0) begin : g_first
      assign s_in = 1'b0;
    end else begin : g_next
      assign s_in = g_stage[j-1].s_out;
    end
    bsmac_sadd u_add (
      .clk(clk), .rst_n(rst_n), .en(active), .clr(start),
      .x(s_in), .y(gate_eff[j] & taps[j]), .sum(s_out)
    );
  end

  // Accumulate adder consumes each product bit as it appears.
  bsmac_sadd u_acc (
    .clk(clk), .rst_n(rst_n), .en(active), .clr(start),
    .x(g_stage[N-1].s_out), .y(c_in), .sum(acc_sum)
  );

  always_comb begin
    res_d   = active & acc_sum;
    valid_d = active;
    last_d  = last;
    done_d  = last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_bit   <= 1'b0;
      res_valid <= 1'b0;
      last_q    <= 1'b0;
      done      <= 1'b0;
    end else begin
      res_bit   <= res_d;
      res_valid <= valid_d;
      last_q    <= last_d;
      done      <= done_d;
    end
  end

endmodule

// File: rtl/bitser_mac_chk.sv
module bitser_mac_chk #(
  parameter int N = 4
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic res_bit,
  input logic res_valid,
  input logic done
);

  localparam int LW = $clog2(2 * N + 3) + 1;
  localparam logic [LW-1:0] RUN = LW'(2 * N + 1);

  logic [LW-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         len_q <= '0;
    else if (start)     len_q <= '0;
    else if (res_valid) len_q <= len_q + LW'(1);
  end

  a_r2_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> res_valid);

  a_r2_valid_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(start));

  a_r2_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (len_q < RUN));

  a_r6_done_full_run: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(start)) |-> (len_q == RUN && !res_valid));

  a_r6_done_follows_valid: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(res_valid));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !res_bit);

endmodule

bind bitser_mac bitser_mac_chk #(.N(N)) u_chk (.*);

// File: tb/bitser_mac_tb.sv
module bitser_mac_tb;

  localparam int N  = 4;
  localparam int RW = 2 * N + 1;

  logic         clk, rst_n, start, mcand_bit, addend_bit;
  logic [N-1:0] mplr;
  logic         res_bit, res_valid, done;

  int errors = 0;
  int checks = 0;

  bitser_mac #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mplr(mplr),
    .mcand_bit(mcand_bit), .addend_bit(addend_bit),
    .res_bit(res_bit), .res_valid(res_valid), .done(done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mode 0: fresh, expect idle outputs in cycle 0
  // mode 1: chained, expect done from previous run in cycle 0 (R9)
  // mode 2: restart over a running computation, cycle 0 not checked (R8)
  task automatic run_mac(input int a, input int b, input int c, input bit junk,
                         input int mode, input bit tail, input string tag);
    logic [RW-1:0] got;
    bit            frame_ok;
    int            exp, last_t;
    exp      = a * b + c;
    got      = '0;
    frame_ok = 1'b1;
    last_t   = tail ? 2 * N + 2 : 2 * N + 1;
    for (int t = 0; t <= last_t; t++) begin
      @(negedge clk);
      if (t == 0 && mode == 0)
        check(!res_valid && !res_bit && !done, {tag, " R7 idle before start"},
              {res_valid, res_bit, done}, 0);
      if (t == 0 && mode == 1)
        check(done && !res_valid, {tag, " R9 done seen with new start"}, {done, res_valid}, 2);
      if (t >= 1 && t <= 2 * N + 1) begin
        if (!res_valid || done) frame_ok = 1'b0;
        got[t-1] = res_bit;
      end
      if (t == 2 * N + 2)
        check(done && !res_valid && !res_bit, {tag, " R6 done after last bit"},
              {done, res_valid, res_bit}, 4);
      start      = (t == 0);
      mplr       = (t == 0 || !junk) ? N'(b) : N'($urandom);
      mcand_bit  = (t < N) ? 1'((a >> t) & 1) : (junk ? 1'($urandom) : 1'b0);
      addend_bit = (t < 2 * N) ? 1'((c >> t) & 1) : (junk ? 1'($urandom) : 1'b0);
    end
    start = 1'b0;
    check(int'(got) == exp, {tag, " R1 result value"}, int'(got), exp);
    check(frame_ok, {tag, " R2 valid framing"}, int'(frame_ok), 1);
    if (junk) begin
      check(int'(got) == exp, {tag, " R3 late multiplicand ignored"}, int'(got), exp);
      check(int'(got) == exp, {tag, " R4 late addend ignored"}, int'(got), exp);
      check(int'(got) == exp, {tag, " R5 multiplier captured"}, int'(got), exp);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; start = 1'b0; mplr = '0; mcand_bit = 1'b0; addend_bit = 1'b0;
    repeat (3) @(negedge clk);
    check(!res_bit && !res_valid && !done, "R10 outputs in reset",
          {res_bit, res_valid, done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!res_bit && !res_valid && !done, "R10 outputs after release",
          {res_bit, res_valid, done}, 0);
  endtask

  task automatic t_idle_inputs;
    mcand_bit = 1'b1; addend_bit = 1'b1; mplr = '1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(!res_bit && !res_valid && !done, "R7 idle inputs ignored",
            {res_bit, res_valid, done}, 0);
    end
    mcand_bit = 1'b0; addend_bit = 1'b0;
  endtask

  task automatic t_exhaustive;
    for (int a = 0; a < (1 << N); a++)
      for (int b = 0; b < (1 << N); b++)
        run_mac(a, b, (a * 37 + b * 11) % (1 << (2 * N)), bit'((a ^ b) & 1), 0, 1'b1, "exh");
  endtask

  task automatic t_corners;
    run_mac((1 << N) - 1, (1 << N) - 1, (1 << (2 * N)) - 1, 1'b1, 0, 1'b1, "max");
    run_mac(0, 0, 0, 1'b1, 0, 1'b1, "zero");
    run_mac((1 << N) - 1, 0, (1 << (2 * N)) - 1, 1'b0, 0, 1'b1, "b0");
  endtask

  task automatic t_restart;
    for (int t = 0; t < 3; t++) begin
      @(negedge clk);
      start      = (t == 0);
      mplr       = N'(9);
      mcand_bit  = 1'b1;
      addend_bit = 1'b1;
    end
    run_mac(11, 13, 77, 1'b0, 2, 1'b1, "R8 restart");
  endtask

  task automatic t_back_to_back;
    run_mac(15, 14, 200, 1'b0, 0, 1'b0, "R9 first");
    run_mac(7, 9, 255, 1'b1, 1, 1'b1, "R9 second");
  endtask

  initial begin
    t_reset();
    t_idle_inputs();
    t_corners();
    t_exhaustive();
    t_restart();
    t_back_to_back();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule